// File: doc/BRIEF.md
# Link Power Status Interface Controller

This block tracks a link-power-status line driven by a link-layer controller. It decides what state the parallel interface between the physical layer and the link should be in. A saturating counter measures how many consecutive system-clock samples of the line have been low. Two thresholds on that count separate a brief or pulsed low from a real power-down. The first threshold drops the interface into a reset state, where the system clock keeps running. The second, longer one moves it to a disabled state, where the system clock is also stopped.

The block drives three enables for the surrounding logic:
- one for the control/data outputs, which are forced to zero when the enable is low;
- one for accepting the link request input;
- one for the system clock output.

It also reports:
- the interface state as a 2-bit code;
- an LLC-active flag, which combines link power status with a software link-control bit;
- a low-power-mode request, raised when the interface is disabled and every port is idle.

The named states are NORMAL, LINK_RESET, DISABLED, CLK_WAKE and INIT. The named transitions are:
- NORMAL to LINK_RESET when the status goes inactive.
- LINK_RESET to DISABLED when the low time passes the long threshold.
- LINK_RESET to INIT when the status is active again.
- DISABLED to CLK_WAKE when the status is active again.
- CLK_WAKE to INIT when the clock-restart wait ends, or back to DISABLED if the status drops.
- INIT to NORMAL after eight cycles, or back to LINK_RESET if the status drops.

Top module: `lps_ifc_ctrl`

## Requirements
- R1: The link status counts as inactive only once more than RST_LIMIT (default 128) consecutive low samples have been taken. One high sample clears the count. A line that is pulsed low for 128 cycles or fewer at a time never leaves NORMAL.
- R2: From NORMAL, the state code becomes 01 (LINK_RESET) on the clock edge after the 129th consecutive low sample. In this state data_en and req_en are 0 and clk_en stays 1.
- R3: When the low time exceeds DIS_LIMIT (default 1280) samples, the state moves from LINK_RESET to DISABLED on the edge after the 1281st low sample. The state code is 10, and clk_en, data_en and req_en are all 0.
- R4: Hardware reset (rst_n low) puts the block in DISABLED, state code 10, with the low-time count saturated. The status therefore stays inactive, and the block stays DISABLED, until a high sample is taken.
- R5: From LINK_RESET, an active status leads to INIT (code 11) on the following edge. The block holds INIT for exactly 8 cycles and then enters NORMAL.
- R6: From DISABLED, an active status leads to CLK_WAKE on the following edge. CLK_WAKE reports code 10 with clk_en 1 and lasts WAKE_CYC cycles (default 16). INIT (8 cycles) then follows, and then NORMAL.
- R7: The interface state never depends on link_ctrl. The output llc_active is 1 exactly when the status is active and link_ctrl is 1.
- R8: lowpwr_req is set on the edge after the state is DISABLED while ports_idle is 1. It is cleared on the edge after the status is active or port_event is 1.
- R9: In NORMAL (code 00), data_en, req_en and clk_en are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| lps_in | input | 1 | Link power status line from the link controller |
| link_ctrl | input | 1 | Software link-control bit |
| ports_idle | input | 1 | All cable ports inactive |
| port_event | input | 1 | Port event requiring wake-up |
| ifc_state | output | 2 | Interface state code: 00 normal, 01 reset, 10 disabled, 11 init |
| data_en | output | 1 | Control/data outputs allowed (0 forces them to zero) |
| req_en | output | 1 | Link request input accepted |
| clk_en | output | 1 | System clock output enabled |
| llc_active | output | 1 | Link controller considered active |
| lowpwr_req | output | 1 | Low-power-mode request |

## Verification
If the low-time counter holds a wrong value, the error appears at ifc_state and at the enables. The state changes at a threshold crossing one or more cycles early or late, so the bench samples the cycles on both sides of the 129th and 1281st low samples. If the sequencing state is wrong, the wake-up timing is wrong: the edge on which clk_en rises, the code changes from 10 to 11, or data_en returns to 1 shifts. That error is visible within the 26 cycles of a wake-up. A wrong low-power flag shows on lowpwr_req one edge after ports_idle, port_event or a high status sample.

// File: rtl/lps_pkg.sv
package lps_pkg;
    // Low two bits are the externally reported state code.
    typedef enum logic [2:0] {
        ST_NORMAL   = 3'b000,
        ST_LINK_RST = 3'b001,
        ST_DISABLED = 3'b010,
        ST_INIT     = 3'b011,
        ST_CLK_WAKE = 3'b110
    } ifc_st_e;
endpackage

// File: rtl/lps_low_timer.sv
module lps_low_timer #(
    parameter int RST_LIMIT = 128,
    parameter int DIS_LIMIT = 1280
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_in,
    output logic lps_active,
    output logic over_dis
);
    localparam int CW = $clog2(DIS_LIMIT + 2);
    localparam logic [CW-1:0] SAT = CW'(DIS_LIMIT + 1);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     low_cnt <= SAT;
        else if (lps_in)                low_cnt <= '0;
        else if (low_cnt <= CW'(DIS_LIMIT)) low_cnt <= low_cnt + 1'b1;
    end

    assign lps_active = (low_cnt <= CW'(RST_LIMIT));
    assign over_dis   = (low_cnt > CW'(DIS_LIMIT));

    // R1
    high_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lps_in |=> lps_active);
endmodule

// File: rtl/lps_ifc_fsm.sv
module lps_ifc_fsm
    import lps_pkg::*;
#(
    parameter int WAKE_CYC = 16,
    parameter int INIT_CYC = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lps_active,
    input  logic       over_dis,
    output ifc_st_e    state,
    output logic [1:0] state_code,
    output logic       data_en,
    output logic       req_en,
    output logic       clk_en
);
    localparam int PMAX = (WAKE_CYC > INIT_CYC) ? WAKE_CYC : INIT_CYC;
    localparam int PW   = $clog2(PMAX + 1);

    ifc_st_e       nxt;
    logic [PW-1:0] ph_cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_NORMAL:   if (!lps_active) nxt = ST_LINK_RST;
            ST_LINK_RST: if (over_dis) nxt = ST_DISABLED;
                         else if (lps_active) nxt = ST_INIT;
            ST_DISABLED: if (lps_active) nxt = ST_CLK_WAKE;
            ST_CLK_WAKE: if (!lps_active) nxt = ST_DISABLED;
                         else if (ph_cnt == PW'(WAKE_CYC - 1)) nxt = ST_INIT;
            ST_INIT:     if (!lps_active) nxt = ST_LINK_RST;
                         else if (ph_cnt == PW'(INIT_CYC - 1)) nxt = ST_NORMAL;
            default:     nxt = ST_DISABLED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_DISABLED;
            ph_cnt <= '0;
        end else begin
            state  <= nxt;
            ph_cnt <= (nxt != state) ? '0 : ph_cnt + 1'b1;
        end
    end

    always_comb begin
        state_code = state[1:0];
        data_en = 1'b0;
        req_en  = 1'b0;
        clk_en  = 1'b1;
        unique case (state)
            ST_NORMAL:   begin data_en = 1'b1; req_en = 1'b1; end
            ST_DISABLED: clk_en = 1'b0;
            default:     ;
        endcase
    end

    // R2
    enter_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_NORMAL && !lps_active) |=> state == ST_LINK_RST);
    // R3
    enter_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LINK_RST && over_dis) |=> state == ST_DISABLED);
    // R5
    reset_to_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LINK_RST && lps_active && !over_dis) |=> state == ST_INIT);
endmodule

// File: rtl/lps_lowpwr_flag.sv
module lps_lowpwr_flag
    import lps_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  ifc_st_e state,
    input  logic    lps_active,
    input  logic    ports_idle,
    input  logic    port_event,
    output logic    lowpwr_req
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   lowpwr_req <= 1'b0;
        else if (lps_active || port_event)            lowpwr_req <= 1'b0;
        else if (state == ST_DISABLED && ports_idle)  lowpwr_req <= 1'b1;
    end

    // R8
    lowpwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lps_active || port_event) |=> !lowpwr_req);
endmodule

// File: rtl/lps_ifc_ctrl.sv
module lps_ifc_ctrl
    import lps_pkg::*;
#(
    parameter int RST_LIMIT = 128,
    parameter int DIS_LIMIT = 1280,
    parameter int WAKE_CYC  = 16,
    parameter int INIT_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lps_in,
    input  logic       link_ctrl,
    input  logic       ports_idle,
    input  logic       port_event,
    output logic [1:0] ifc_state,
    output logic       data_en,
    output logic       req_en,
    output logic       clk_en,
    output logic       llc_active,
    output logic       lowpwr_req
);
    logic    lps_active;
    logic    over_dis;
    ifc_st_e state;

    lps_low_timer #(.RST_LIMIT(RST_LIMIT), .DIS_LIMIT(DIS_LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .lps_in(lps_in),
        .lps_active(lps_active), .over_dis(over_dis)
    );

    lps_ifc_fsm #(.WAKE_CYC(WAKE_CYC), .INIT_CYC(INIT_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .lps_active(lps_active), .over_dis(over_dis),
        .state(state), .state_code(ifc_state),
        .data_en(data_en), .req_en(req_en), .clk_en(clk_en)
    );

    lps_lowpwr_flag u_lowpwr (
        .clk(clk), .rst_n(rst_n), .state(state), .lps_active(lps_active),
        .ports_idle(ports_idle), .port_event(port_event), .lowpwr_req(lowpwr_req)
    );

    // R7: link status and software bit both required
    assign llc_active = lps_active & link_ctrl;
endmodule

// File: tb/sim_lps_ifc_ctrl.sv
`timescale 1ns/100ps
module sim_lps_ifc_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lps_in = 1'b0, link_ctrl = 1'b0, ports_idle = 1'b0, port_event = 1'b0;
    logic [1:0] ifc_state;
    logic data_en, req_en, clk_en, llc_active, lowpwr_req;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lps_ifc_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .link_ctrl(link_ctrl),
        .ports_idle(ports_idle), .port_event(port_event), .ifc_state(ifc_state),
        .data_en(data_en), .req_en(req_en), .clk_en(clk_en),
        .llc_active(llc_active), .lowpwr_req(lowpwr_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_hw_reset;
        chk("R4", "state after reset", ifc_state, 2'b10);
        chk("R4", "clk_en in disabled", {1'b0, clk_en}, 2'b00);
        chk("R4", "data_en in disabled", {1'b0, data_en}, 2'b00);
        chk("R8", "lowpwr with busy ports", {1'b0, lowpwr_req}, 2'b00);
        tick(3);
        chk("R4", "low status keeps disabled", ifc_state, 2'b10);
    endtask

    task automatic t_lowpwr;
        ports_idle = 1'b1; tick(1);
        chk("R8", "lowpwr set", {1'b0, lowpwr_req}, 2'b01);
        port_event = 1'b1; tick(1);
        chk("R8", "lowpwr cleared by event", {1'b0, lowpwr_req}, 2'b00);
        port_event = 1'b0; tick(1);
        chk("R8", "lowpwr set again", {1'b0, lowpwr_req}, 2'b01);
    endtask

    task automatic t_wake_from_disabled;
        lps_in = 1'b1; tick(2);
        chk("R8", "lowpwr cleared by status", {1'b0, lowpwr_req}, 2'b00);
        chk("R6", "wake reports 10", ifc_state, 2'b10);
        chk("R6", "wake clock on", {1'b0, clk_en}, 2'b01);
        tick(15);
        chk("R6", "last wake cycle", ifc_state, 2'b10);
        tick(1);
        chk("R6", "init after wake", ifc_state, 2'b11);
        tick(7);
        chk("R6", "last init cycle", ifc_state, 2'b11);
        chk("R6", "data gated in init", {1'b0, data_en}, 2'b00);
        tick(1);
        chk("R9", "normal reached", ifc_state, 2'b00);
        chk("R9", "enables in normal", {data_en, req_en}, 2'b11);
        chk("R9", "clock in normal", {1'b0, clk_en}, 2'b01);
        ports_idle = 1'b0;
    endtask

    task automatic t_llc_flag;
        link_ctrl = 1'b1; tick(1);
        chk("R7", "llc active", {1'b0, llc_active}, 2'b01);
        link_ctrl = 1'b0; tick(1);
        chk("R7", "llc inactive with bit clear", {1'b0, llc_active}, 2'b00);
        chk("R7", "state ignores link bit", ifc_state, 2'b00);
    endtask

    task automatic t_pulsed;
        lps_in = 1'b0; tick(128);
        chk("R1", "128 lows keep normal", ifc_state, 2'b00);
        for (int k = 0; k < 3; k++) begin
            lps_in = 1'b1; tick(1);
            lps_in = 1'b0; tick(100);
        end
        lps_in = 1'b1; tick(2);
        chk("R1", "pulsed line stays normal", ifc_state, 2'b00);
    endtask

    task automatic t_enter_reset;
        link_ctrl = 1'b1;
        lps_in = 1'b0; tick(129);
        chk("R2", "still normal after 129 lows", ifc_state, 2'b00);
        tick(1);
        chk("R2", "reset state", ifc_state, 2'b01);
        chk("R2", "data/req gated", {data_en, req_en}, 2'b00);
        chk("R2", "clock kept", {1'b0, clk_en}, 2'b01);
        chk("R7", "llc off despite link bit", {1'b0, llc_active}, 2'b00);
        link_ctrl = 1'b0;
    endtask

    task automatic t_reset_recover;
        lps_in = 1'b1; tick(9);
        chk("R5", "init last cycle", ifc_state, 2'b11);
        tick(1);
        chk("R5", "normal after init", ifc_state, 2'b00);
    endtask

    task automatic t_enter_disabled;
        lps_in = 1'b0; tick(130);
        chk("R2", "reset before long limit", ifc_state, 2'b01);
        tick(1151);
        chk("R3", "still reset at 1281 lows", ifc_state, 2'b01);
        tick(1);
        chk("R3", "disabled", ifc_state, 2'b10);
        chk("R3", "clock gated", {1'b0, clk_en}, 2'b00);
        lps_in = 1'b1; tick(26);
        chk("R6", "normal after full wake", ifc_state, 2'b00);
    endtask

    task automatic t_hw_reset_mid;
        rst_n = 1'b0; tick(1);
        chk("R4", "hw reset from normal", ifc_state, 2'b10);
        rst_n = 1'b1;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_hw_reset();
        t_lowpwr();
        t_wake_from_disabled();
        t_llc_flag();
        t_pulsed();
        t_enter_reset();
        t_reset_recover();
        t_enter_disabled();
        t_hw_reset_mid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule